// File: doc/BRIEF.md
# Timing-Line Sequencer

The block steps through a programmable chain of buckets, one bucket per clock, and drives a set of static timing lines and a set of dynamic timing lines from per-bucket memory words. A next-address memory holds the chain: each entry names the bucket that follows. A static memory holds the static line pattern and a turn-reference flag for every bucket. Two dynamic memories, group A and group B, hold alternative dynamic patterns. A group select picks which of them reaches the dynamic lines.

A simple host port (select, address, write data, write strobe) loads and reads back all four memories and a control word. While the sequencer is stopped, the next-address and static memories are addressed from the host. While it runs, they are addressed from the chain. Each dynamic memory has its own on control. When a dynamic memory is on, the chain addresses it. When it is off, the host addresses it.

In sync mode the block checks, on every bucket, whether the bucket carries the turn-reference flag and whether the external turn marker was present. If the flag and the marker disagree, a hold flag is raised. When the reference bucket is reached without a marker, the sequencer parks on that bucket until a marker arrives. In freerun mode the chain is followed regardless of the marker.

Top module: `timeline_sequencer`

## Requirements
- R1: After reset the control word reads 0x08: stopped, both dynamic memories off, group B selected, outputs disabled, sync mode. The static lines, dynamic lines and hold flag are all zero.
- R2: Host select codes are: 0 next-address, 1 static, 2 dynamic A, 3 dynamic B, 4 control word. The control bits are: bit0 run, bit1 A on, bit2 B on, bit3 select B, bit4 output enable, bit5 freerun. A read returns the addressed word after the next clock edge. Writes to the next-address or static memory are ignored while running. Writes to a dynamic memory are ignored while that memory is on.
- R3: While running, the reported bucket advances each clock to the next-address entry of the previous bucket. The static lines then show bits 11:0 of that previous bucket's static word. Bit 12 of a static word is the turn-reference flag.
- R4: While stopped, the reported bucket follows the host address one edge later. The first bucket after starting is the next-address entry of the last host-addressed location.
- R5: With output enable clear, the static and dynamic lines are zero one edge later.
- R6: With output enable set, the dynamic lines show the selected group's word for the previous bucket if that group is on, and zero otherwise.
- R7: In sync mode, a reference bucket read without the marker keeps the sequencer on that bucket for the next cycle and sets hold.
- R8: In sync mode, a reference bucket read with the marker present clears hold and the chain advances.
- R9: In sync mode, a marker seen on a non-reference bucket sets hold, and stepping continues until the reference bucket.
- R10: In freerun mode the sequencer never parks and hold is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| host_we | input | 1 | Host write strobe |
| host_sel | input | 3 | Host target select (0..4) |
| host_addr | input | 11 | Host memory address |
| host_wdata | input | 13 | Host write data |
| host_rdata | output | 13 | Host read data, valid after the edge following the request |
| turn_marker | input | 1 | External once-per-turn marker, sampled each clock |
| static_lines | output | 12 | Static timing lines |
| dyn_lines | output | 11 | Dynamic timing lines |
| cur_bucket | output | 11 | Bucket whose words are currently read |
| hold | output | 1 | Synchronisation lost, set until a coincident marker |

## Verification
The assertions take the turn marker to be a level that is sampled once per clock. They also take the control word to change only through host writes, so that every gating property uses the control value in force before the edge. The stimulus changes the marker and the host signals only on the falling edge. It keeps the chain a closed loop of programmed entries, with a single reference bucket. It raises the marker on the reference bucket three times in four and on other buckets rarely, so that park, resume and early-marker cases all occur in sync mode as well as freerun mode.

// File: rtl/seqr_pkg.sv
package seqr_pkg;
  typedef struct packed {
    logic freerun;
    logic oe;
    logic sel_b;
    logic b_on;
    logic a_on;
    logic run;
  } ctl_t;

  localparam ctl_t CTL_RESET = '{freerun: 1'b0, oe: 1'b0, sel_b: 1'b1,
                                 b_on: 1'b0, a_on: 1'b0, run: 1'b0};

  typedef enum logic [2:0] {
    SEL_NEXT = 3'd0,
    SEL_STAT = 3'd1,
    SEL_DYNA = 3'd2,
    SEL_DYNB = 3'd3,
    SEL_CTRL = 3'd4
  } hsel_e;
endpackage

// File: rtl/seqr_ram.sv
module seqr_ram #(
  parameter int DEPTH = 1113,
  parameter int W     = 8,
  parameter int AW    = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] addr,
  input  logic [W-1:0]  wdata,
  output logic [W-1:0]  rdata
);
  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk) begin
    if (we) mem[addr] <= wdata;
  end

  always_ff @(posedge clk) begin
    if (rst) rdata <= '0;
    else     rdata <= mem[addr];
  end
endmodule

// File: rtl/seqr_core.sv
module seqr_core #(
  parameter int AW = 11
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          run,
  input  logic          freerun,
  input  logic          ref_bit,
  input  logic          marker,
  input  logic [AW-1:0] next_ptr,
  input  logic [AW-1:0] host_addr,
  output logic [AW-1:0] seq_addr,
  output logic [AW-1:0] ram_addr,
  output logic [AW-1:0] bucket,
  output logic          hold
);
  logic marker_q;
  logic park;

  // park on the reference bucket while the marker is absent (sync mode)
  assign park     = run && !freerun && ref_bit && !marker_q;
  assign seq_addr = park ? bucket : next_ptr;
  assign ram_addr = run ? seq_addr : host_addr;

  always_ff @(posedge clk) begin
    if (rst) begin
      marker_q <= 1'b0;
      bucket   <= '0;
      hold     <= 1'b0;
    end else begin
      marker_q <= marker;
      bucket   <= ram_addr;
      if (run) begin
        if (freerun)                    hold <= 1'b0;
        else if (ref_bit && marker_q)   hold <= 1'b0;
        else if (ref_bit != marker_q)   hold <= 1'b1;
      end
    end
  end
endmodule

// File: rtl/timeline_sequencer.sv
module timeline_sequencer
  import seqr_pkg::*;
#(
  parameter int DEPTH  = 1113,
  parameter int N_STAT = 12,
  parameter int N_DYN  = 11,
  localparam int AW    = $clog2(DEPTH),
  localparam int SW    = N_STAT + 1,
  localparam int CTLW  = $bits(ctl_t),
  localparam int M1    = (SW > AW) ? SW : AW,
  localparam int M2    = (N_DYN > CTLW) ? N_DYN : CTLW,
  localparam int HDW   = (M1 > M2) ? M1 : M2
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              host_we,
  input  logic [2:0]        host_sel,
  input  logic [AW-1:0]     host_addr,
  input  logic [HDW-1:0]    host_wdata,
  output logic [HDW-1:0]    host_rdata,
  input  logic              turn_marker,
  output logic [N_STAT-1:0] static_lines,
  output logic [N_DYN-1:0]  dyn_lines,
  output logic [AW-1:0]     cur_bucket,
  output logic              hold
);
  ctl_t  ctl;
  hsel_e hsel, sel_q;
  logic  run_on, free_mode, oe, sel_b;
  logic [1:0] grp_on;

  logic [AW-1:0]    na_rd, seq_addr, ram_addr;
  logic [SW-1:0]    st_rd;
  logic [N_DYN-1:0] dyn_rd [2];
  logic [AW-1:0]    dyn_addr [2];
  logic [1:0]       dyn_we;
  logic             na_we, st_we;
  logic [N_DYN-1:0] dyn_pick;
  logic             pick_on;

  assign hsel      = hsel_e'(host_sel);
  assign run_on    = ctl.run;
  assign free_mode = ctl.freerun;
  assign oe        = ctl.oe;
  assign sel_b     = ctl.sel_b;
  assign grp_on    = {ctl.b_on, ctl.a_on};

  always_ff @(posedge clk) begin
    if (rst) begin
      ctl   <= CTL_RESET;
      sel_q <= SEL_NEXT;
    end else begin
      sel_q <= hsel;
      if (host_we && hsel == SEL_CTRL) ctl <= ctl_t'(host_wdata[CTLW-1:0]);
    end
  end

  seqr_core #(.AW(AW)) u_core (
    .clk(clk), .rst(rst), .run(run_on), .freerun(free_mode),
    .ref_bit(st_rd[N_STAT]), .marker(turn_marker), .next_ptr(na_rd),
    .host_addr(host_addr), .seq_addr(seq_addr), .ram_addr(ram_addr),
    .bucket(cur_bucket), .hold(hold)
  );

  assign na_we = host_we && hsel == SEL_NEXT && !run_on;
  assign st_we = host_we && hsel == SEL_STAT && !run_on;

  seqr_ram #(.DEPTH(DEPTH), .W(AW), .AW(AW)) u_next (
    .clk(clk), .rst(rst), .we(na_we), .addr(ram_addr),
    .wdata(host_wdata[AW-1:0]), .rdata(na_rd)
  );

  seqr_ram #(.DEPTH(DEPTH), .W(SW), .AW(AW)) u_stat (
    .clk(clk), .rst(rst), .we(st_we), .addr(ram_addr),
    .wdata(host_wdata[SW-1:0]), .rdata(st_rd)
  );

  for (genvar g = 0; g < 2; g++) begin : g_dyn
    localparam hsel_e MY_SEL = (g == 0) ? SEL_DYNA : SEL_DYNB;
    assign dyn_addr[g] = grp_on[g] ? seq_addr : host_addr;
    assign dyn_we[g]   = host_we && hsel == MY_SEL && !grp_on[g];
    seqr_ram #(.DEPTH(DEPTH), .W(N_DYN), .AW(AW)) u_ram (
      .clk(clk), .rst(rst), .we(dyn_we[g]), .addr(dyn_addr[g]),
      .wdata(host_wdata[N_DYN-1:0]), .rdata(dyn_rd[g])
    );
  end

  assign dyn_pick = sel_b ? dyn_rd[1] : dyn_rd[0];
  assign pick_on  = sel_b ? grp_on[1] : grp_on[0];

  always_ff @(posedge clk) begin
    if (rst) begin
      static_lines <= '0;
      dyn_lines    <= '0;
    end else begin
      static_lines <= oe ? st_rd[N_STAT-1:0] : '0;
      dyn_lines    <= (oe && pick_on) ? dyn_pick : '0;
    end
  end

  always_comb begin
    case (sel_q)
      SEL_NEXT: host_rdata = HDW'(na_rd);
      SEL_STAT: host_rdata = HDW'(st_rd);
      SEL_DYNA: host_rdata = HDW'(dyn_rd[0]);
      SEL_DYNB: host_rdata = HDW'(dyn_rd[1]);
      SEL_CTRL: host_rdata = HDW'(ctl);
      default:  host_rdata = '0;
    endcase
  end
endmodule

// File: rtl/seqr_checker.sv
module seqr_checker #(
  parameter int AW = 11,
  parameter int NS = 12,
  parameter int ND = 11
) (
  input logic          clk,
  input logic          rst,
  input logic          run,
  input logic          freerun,
  input logic          oe,
  input logic          sel_b,
  input logic          a_on,
  input logic          b_on,
  input logic          ref_bit,
  input logic          marker,
  input logic [AW-1:0] host_addr,
  input logic [AW-1:0] bucket,
  input logic          hold,
  input logic [NS-1:0] static_lines,
  input logic [ND-1:0] dyn_lines
);
  logic mk_q;
  always_ff @(posedge clk) begin
    if (rst) mk_q <= 1'b0;
    else     mk_q <= marker;
  end

  AST_GATED_OFF: assert property (@(posedge clk) disable iff (rst)
    !oe |=> (static_lines == '0 && dyn_lines == '0));                 // R5
  AST_DYN_DARK: assert property (@(posedge clk) disable iff (rst)
    (sel_b ? !b_on : !a_on) |=> dyn_lines == '0);                     // R6
  AST_PARK_STAY: assert property (@(posedge clk) disable iff (rst)
    (run && !freerun && ref_bit && !mk_q) |=> (bucket == $past(bucket) && hold)); // R7
  AST_RESUME_CLEAR: assert property (@(posedge clk) disable iff (rst)
    (run && !freerun && ref_bit && mk_q) |=> !hold);                  // R8
  AST_FREE_NO_HOLD: assert property (@(posedge clk) disable iff (rst)
    (run && freerun) |=> !hold);                                      // R10
  AST_HOST_ADDR: assert property (@(posedge clk) disable iff (rst)
    !run |=> bucket == $past(host_addr));                             // R4
endmodule

bind timeline_sequencer seqr_checker #(.AW(AW), .NS(N_STAT), .ND(N_DYN)) u_chk (
  .clk(clk), .rst(rst), .run(run_on), .freerun(free_mode), .oe(oe),
  .sel_b(sel_b), .a_on(grp_on[0]), .b_on(grp_on[1]), .ref_bit(st_rd[N_STAT]),
  .marker(turn_marker), .host_addr(host_addr), .bucket(cur_bucket),
  .hold(hold), .static_lines(static_lines), .dyn_lines(dyn_lines)
);

// File: tb/tb_timeline_sequencer.sv
`timescale 1ns/1ps
module tb_timeline_sequencer;
  localparam int DEPTH = 1113;
  localparam int AW = 11;
  localparam int HDW = 13;
  localparam int REFB = 6;
  localparam int PRE = 5;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic host_we = 1'b0;
  logic [2:0] host_sel = '0;
  logic [AW-1:0] host_addr = '0;
  logic [HDW-1:0] host_wdata = '0;
  logic [HDW-1:0] host_rdata;
  logic turn_marker = 1'b0;
  logic [11:0] static_lines;
  logic [10:0] dyn_lines;
  logic [AW-1:0] cur_bucket;
  logic hold;

  int n_tests = 0;
  int n_fail = 0;
  int na_m[8], st_m[8], da_m[8], db_m[8];
  int ph = 0;

  always #2 clk = ~clk;

  timeline_sequencer dut (
    .clk(clk), .rst(rst), .host_we(host_we), .host_sel(host_sel),
    .host_addr(host_addr), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .turn_marker(turn_marker), .static_lines(static_lines),
    .dyn_lines(dyn_lines), .cur_bucket(cur_bucket), .hold(hold)
  );

  task automatic chk(input string tag, input int act, input int exp);
    n_tests++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic report();
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  endtask

  task automatic host_wr(input int sel, input int addr, input int data);
    host_we = 1'b1; host_sel = 3'(sel); host_addr = AW'(addr); host_wdata = HDW'(data);
    @(negedge clk);
    host_we = 1'b0;
  endtask

  task automatic host_rd(input int sel, input int addr, output int val);
    host_we = 1'b0; host_sel = 3'(sel); host_addr = AW'(addr);
    @(negedge clk);
    val = int'(host_rdata);
  endtask

  function automatic bit is_ref(input int b);
    return b == REFB;
  endfunction

  task automatic run_phase(input int ctrl, input int n);
    int rv, pb, nb, nh, es, ed;
    bit pm, mk, park, fr, oe, selb, on_sel;
    fr = ctrl[5]; oe = ctrl[4]; selb = ctrl[3];
    on_sel = selb ? ctrl[2] : ctrl[1];
    turn_marker = 1'b0;
    host_rd(1, PRE, rv);
    chk("R2 static readback", rv, st_m[PRE]);
    host_wr(4, PRE, ctrl);
    @(negedge clk);
    chk("R4 first bucket after start", int'(cur_bucket), 0);
    if (fr) ph = 0;
    chk(fr ? "R10 hold at start" : "R7 hold at start", int'(hold), ph);
    pb = 0; pm = 1'b0;
    for (int k = 0; k < n; k++) begin
      park = !fr && is_ref(pb) && !pm;
      nb = park ? pb : na_m[pb];
      if (fr) nh = 0;
      else if (is_ref(pb) && pm) nh = 0;
      else if (is_ref(pb) != pm) nh = 1;
      else nh = ph;
      es = oe ? (st_m[pb] & 12'hFFF) : 0;
      ed = (oe && on_sel) ? (selb ? db_m[pb] : da_m[pb]) : 0;
      mk = is_ref(nb) ? ($urandom % 4 != 0) : ($urandom % 12 == 0);
      turn_marker = mk;
      host_we = 1'b1;
      if (k == n - 1) begin
        host_sel = 3'd4; host_addr = AW'(PRE); host_wdata = HDW'(ctrl & ~1);
      end else begin
        host_sel = 3'(k % 2); host_addr = AW'(REFB); host_wdata = '0;
      end
      @(negedge clk);
      if (park) chk("R7 parked bucket", int'(cur_bucket), nb);
      else if (fr) chk("R10 freerun bucket", int'(cur_bucket), nb);
      else chk("R3 next bucket", int'(cur_bucket), nb);
      if (fr) chk("R10 hold clear", int'(hold), nh);
      else if (is_ref(pb) && pm) chk("R8 resume hold", int'(hold), nh);
      else if (!is_ref(pb) && pm) chk("R9 early marker hold", int'(hold), nh);
      else chk("R7 hold", int'(hold), nh);
      chk(oe ? "R3 static lines" : "R5 static gated", int'(static_lines), es);
      chk(oe ? "R6 dynamic lines" : "R5 dynamic gated", int'(dyn_lines), ed);
      pb = nb; pm = mk; ph = nh;
    end
    host_we = 1'b0; turn_marker = 1'b0;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_tests++; n_fail++;
    $display("FAIL watchdog expired R1 actual=hung expected=done");
    report();
  end

  initial begin
    int ch[8];
    int rv;
    void'($urandom(32'd20251));
    ch = '{0, 3, 1, 6, 2, 7, 4, 5};
    for (int i = 0; i < 8; i++) begin
      na_m[ch[i]] = ch[(i + 1) % 8];
      st_m[i] = int'($urandom % 4096) | ((i == REFB) ? 4096 : 0);
      da_m[i] = int'($urandom % 2048);
      db_m[i] = int'($urandom % 2048);
    end
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    chk("R1 static lines after reset", int'(static_lines), 0);
    chk("R1 dynamic lines after reset", int'(dyn_lines), 0);
    chk("R1 hold after reset", int'(hold), 0);
    host_rd(4, 0, rv);
    chk("R1 control word after reset", rv, 8);

    for (int i = 0; i < 8; i++) begin
      host_wr(0, i, na_m[i]);
      host_wr(1, i, st_m[i]);
      host_wr(2, i, da_m[i]);
      host_wr(3, i, db_m[i]);
    end
    host_wr(0, DEPTH - 1, 11'h2A5);
    host_rd(0, DEPTH - 1, rv);
    chk("R2 next-address top entry", rv, 11'h2A5);
    host_rd(0, 1, rv);
    chk("R2 next-address readback", rv, na_m[1]);
    host_rd(2, 3, rv);
    chk("R2 dynamic A readback", rv, da_m[3]);
    host_rd(3, 7, rv);
    chk("R2 dynamic B readback", rv, db_m[7]);

    run_phase(6'h17, 600);
    host_wr(2, 2, (~da_m[2]) & 11'h7FF);
    host_wr(4, PRE, 8);
    host_rd(2, 2, rv);
    chk("R2 dynamic write ignored while on", rv, da_m[2]);
    host_rd(1, REFB, rv);
    chk("R2 static write ignored while running", rv, st_m[REFB]);
    host_rd(0, REFB, rv);
    chk("R2 next-address write ignored while running", rv, na_m[REFB]);

    run_phase(6'h3D, 300);
    run_phase(6'h0F, 200);
    run_phase(6'h15, 200);
    run_phase(6'h1D, 300);
    report();
  end
endmodule